// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the serial-bus front end of a register-mapped sensor. It watches an oversampled two-wire clock and data pair and passes both lines through a synchronizer and a glitch filter. It recognises START and STOP conditions and answers a 7-bit address made of a fixed upper nibble and three strap pins. It reaches a bank of 16-bit registers through a pointer: a write access sets the pointer and may then write one register, and a read access returns the register the pointer selects. The block only reports when it wants SDA pulled low. An open-drain pad outside the block turns that into the bus level, and the register contents live in a register file outside the block.

The register file port is plain. The pointer is always visible on `reg_addr_o`. A write is a single-cycle `wr_en_o` pulse that the register file must accept in that cycle, so the port has no back-pressure. Read data is taken from `rd_data_i` at one defined moment during the access. An optional clock-low timeout, counted in system clocks, drops any access in progress and releases SDA if a master stalls the bus.

Top module: `tws_sensor_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `wr_en_o` are low and the engine waits for a START.
- R2: The address byte is taken MSB first. Its upper seven bits must equal binary 0011 followed by strap bits 2, 1 and 0. Its bit 0 selects write (0) or read (1). A matching address is acknowledged by pulling SDA low for the ninth clock.
- R3: A non-matching address, including the all-zero general call, is not acknowledged, and the access that follows causes no acknowledge, no SDA drive and no register write.
- R4: The strap pins are captured at each START. A change of the straps after the START has no effect on the address that access matches.
- R5: In a write access, the first byte after the address is acknowledged and loaded into the pointer: its low `PTR_W` bits appear on `reg_addr_o`.
- R6: The two bytes after the pointer are acknowledged and produce exactly one `wr_en_o` pulse, with `wr_data_o` = {first byte, second byte} and `reg_addr_o` equal to the pointer. Any further byte in the same access is not acknowledged.
- R7: A write access that ends after the pointer byte, or after only one data byte, writes nothing. The pointer keeps its value for later reads.
- R8: A read access captures `rd_data_i` at the end of the address acknowledge. It then sends bits 15..8 followed by bits 7..0, MSB first. Each master acknowledge fetches the other byte again (high, low, high, ...). A master NACK ends the transfer with SDA released.
- R9: A STOP returns the engine to idle from any state. A repeated START begins a new address phase without a STOP.
- R10: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks are ignored.
- R11: With `to_en_i` high, SCL held low for `TO_CYCLES` system clocks returns the engine to idle and releases SDA. With `to_en_i` low, the engine keeps its state and its SDA drive for any clock-low time.
- R12: `sda_oe_o` changes only while the filtered SCL is low, and `wr_en_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| sda_oe_o | output | 1 | High to pull SDA low |
| strap_i | input | 3 | Address strap pins, bit 2 down to bit 0 |
| to_en_i | input | 1 | Enables the clock-low timeout |
| reg_addr_o | output | PTR_W | Current pointer, the register selected |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_data_o | output | 16 | Register write data |
| rd_data_i | input | 16 | Contents of the selected register |

## Verification
The timeout expiry and the slave's own acknowledge drive can land in the same cycle. When they do, the timeout must win over a bit the byte engine is still holding on the bus. The bench provokes this by stopping SCL low right in the ninth clock of a matching address, while the slave is pulling SDA low. It checks that the drive is still present shortly before the window ends and gone shortly after. It then repeats the stall with the timeout disabled and expects the drive to hold well past the window, and to end normally once the clock resumes.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam logic [3:0] ADDR_PREFIX = 4'b0011;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WHI, ST_WLO, ST_READ, ST_SKIP
  } tws_st_e;
endpackage

// File: rtl/tws_glitch_filter.sv
module tws_glitch_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(LEN + 1);
  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; q_o <= 1'b1; cnt <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
      if (s2 == q_o) cnt <= '0;
      else if (cnt == CW'(LEN - 1)) begin
        q_o <= s2;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tws_timeout.sv
module tws_timeout #(
  parameter int TO_CYCLES = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_f,
  output logic hit_o
);
  localparam int CW = $clog2(TO_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (scl_f) cnt <= '0;
    else if (cnt != CW'(TO_CYCLES)) cnt <= cnt + 1'b1;
  end

  assign hit_o = en_i & ~scl_f & (cnt == CW'(TO_CYCLES - 1));
endmodule

// File: rtl/tws_byte_engine.sv
module tws_byte_engine
  import tws_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             to_hit,
  input  logic [2:0]       strap_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o
);
  tws_st_e st, nxt;
  logic scl_q, sda_q, in_ack, mack, lo_next;
  logic [3:0] cnt;
  logic [BYTE_W-1:0] sh, tx, hi_q;
  logic [REG_W-1:0] rd_q;
  logic [2:0] strap_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      in_ack <= 1'b0; mack <= 1'b0; lo_next <= 1'b0; cnt <= '0;
      sh <= '0; tx <= '0; hi_q <= '0; rd_q <= '0; strap_q <= '0;
      ptr_o <= '0; wr_en_o <= 1'b0; wr_data_o <= '0; sda_oe_o <= 1'b0;
    end else begin
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      wr_en_o <= 1'b0;
      if (to_hit || stop_det) begin
        st <= ST_IDLE; in_ack <= 1'b0; sda_oe_o <= 1'b0;
      end else if (start_det) begin
        st <= ST_ADDR; cnt <= '0; in_ack <= 1'b0; sda_oe_o <= 1'b0;
        strap_q <= strap_i;
      end else if (st == ST_READ) begin
        if (scl_rise) begin
          if (in_ack) mack <= ~sda_f;
          else cnt <= cnt + 1'b1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            if (mack) begin
              tx       <= lo_next ? rd_q[BYTE_W-1:0] : rd_q[REG_W-1:BYTE_W];
              sda_oe_o <= lo_next ? ~rd_q[BYTE_W-1] : ~rd_q[REG_W-1];
              lo_next  <= ~lo_next;
            end else begin
              st <= ST_SKIP; sda_oe_o <= 1'b0;
            end
          end else if (cnt == 4'd8) begin
            sda_oe_o <= 1'b0; in_ack <= 1'b1;
          end else begin
            tx       <= tx << 1;
            sda_oe_o <= ~tx[BYTE_W-2];
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && !in_ack && cnt < 4'd8) begin
          sh  <= {sh[BYTE_W-2:0], sda_f};
          cnt <= cnt + 1'b1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; cnt <= '0; st <= nxt;
            if (nxt == ST_READ) begin
              rd_q     <= rd_data_i;
              tx       <= rd_data_i[REG_W-1:BYTE_W];
              sda_oe_o <= ~rd_data_i[REG_W-1];
              lo_next  <= 1'b1;
            end else sda_oe_o <= 1'b0;
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            nxt    <= ST_SKIP;
            case (st)
              ST_ADDR: if (sh[7:1] == {ADDR_PREFIX, strap_q}) begin
                sda_oe_o <= 1'b1;
                nxt      <= sh[0] ? ST_READ : ST_PTR;
              end
              ST_PTR: begin
                ptr_o <= sh[PTR_W-1:0]; sda_oe_o <= 1'b1; nxt <= ST_WHI;
              end
              ST_WHI: begin
                hi_q <= sh; sda_oe_o <= 1'b1; nxt <= ST_WLO;
              end
              ST_WLO: begin
                wr_en_o <= 1'b1; wr_data_o <= {hi_q, sh}; sda_oe_o <= 1'b1;
              end
              default: sda_oe_o <= 1'b0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tws_sensor_slave.sv
module tws_sensor_slave #(
  parameter int PTR_W     = 4,
  parameter int FILT_LEN  = 4,
  parameter int TO_CYCLES = 1500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [2:0]       strap_i,
  input  logic             to_en_i,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic             wr_en_o,
  output logic [15:0]      wr_data_o,
  input  logic [15:0]      rd_data_i
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, filt;
  logic scl_f, sda_f, to_hit;

  assign raw = {scl_i, sda_i};
  for (genvar g = 0; g < NLINES; g++) begin : g_flt
    tws_glitch_filter #(.LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .d_i(raw[g]), .q_o(filt[g])
    );
  end
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  tws_timeout #(.TO_CYCLES(TO_CYCLES)) u_to (
    .clk(clk), .rst_n(rst_n), .en_i(to_en_i), .scl_f(scl_f), .hit_o(to_hit)
  );

  tws_byte_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .to_hit(to_hit),
    .strap_i(strap_i), .ptr_o(reg_addr_o), .wr_en_o(wr_en_o),
    .wr_data_o(wr_data_o), .rd_data_i(rd_data_i), .sda_oe_o(sda_oe_o)
  );
endmodule

// File: rtl/tws_sensor_slave_chk.sv
module tws_sensor_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic to_hit,
  input logic sda_oe_o,
  input logic wr_en_o
);
  a_r11_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> !sda_oe_o);

  a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_f);

  a_r12_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  a_r6_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !scl_f);
endmodule

bind tws_sensor_slave tws_sensor_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .to_hit(to_hit),
  .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o)
);

// File: tb/tws_sensor_slave_test.sv
module tws_sensor_slave_test;
  localparam int H  = 20;
  localparam int TO = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, glitch = 1'b0;
  logic [2:0] strap = 3'd0;
  logic to_en = 1'b1;
  logic sda_oe, wr_en;
  logic [3:0] reg_addr;
  logic [15:0] wr_data, rd_data;
  logic [15:0] mem [16];
  int wr_cnt = 0, checks = 0, errors = 0;
  bit done = 1'b0;
  wire sda_line = !(m_low || sda_oe || glitch);

  always #10 clk = ~clk;

  tws_sensor_slave #(.PTR_W(4), .FILT_LEN(4), .TO_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .to_en_i(to_en), .reg_addr_o(reg_addr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .rd_data_i(rd_data)
  );

  assign rd_data = mem[reg_addr];
  always @(posedge clk) if (wr_en) begin
    mem[reg_addr] <= wr_data;
    wr_cnt <= wr_cnt + 1;
  end

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0011, s, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    if (!scl) begin
      wt(H/2); m_low = 1'b0; wt(H/2); scl = 1'b1; wt(H);
    end
    m_low = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(H/2); m_low = 1'b1; wt(H/2); scl = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask

  task automatic send8(input logic [7:0] b, input bit glt);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); m_low = !b[i]; wt(H/2); scl = 1'b1;
      if (glt && b[i]) begin
        wt(H/2); glitch = 1'b1; wt(2); glitch = 1'b0; wt(H/2 - 2);
      end else wt(H);
      scl = 1'b0;
    end
  endtask

  task automatic ack_clk(output bit ack);
    wt(H/2); m_low = 1'b0; wt(H/2); scl = 1'b1; wt(H/2);
    ack = !sda_line; wt(H/2); scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, input bit glt, output bit ack);
    send8(b, glt); ack_clk(ack);
  endtask

  task automatic rbyte(input bit m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); m_low = 1'b0; wt(H/2); scl = 1'b1; wt(H/2);
      b[i] = sda_line; wt(H/2); scl = 1'b0;
    end
    wt(H/2); m_low = m_ack; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] p, input logic [15:0] d,
                           input bit glt, output bit [2:0] acks);
    bit k;
    bus_start;
    wbyte(a, 1'b0, k); acks[2] = k;
    wbyte(p, 1'b0, k); acks[1] = k;
    wbyte(d[15:8], glt, k); acks[0] = k;
    wbyte(d[7:0], glt, k); acks[0] = acks[0] & k;
    bus_stop;
  endtask

  task automatic read_n(input logic [7:0] a, input int n, output bit ack, output logic [23:0] v);
    logic [7:0] b;
    bus_start;
    wbyte(a, 1'b0, ack);
    v = '0;
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      v = {v[15:0], b};
    end
    bus_stop;
  endtask

  initial begin
    bit [2:0] acks;
    bit k;
    logic [23:0] v;
    int w0;
    for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i);
    void'($urandom(32'h5EED));
    wt(5);
    // R1 reset state
    chk(!sda_oe && !wr_en, "R1 reset outputs", {sda_oe, wr_en}, 0);
    rst_n = 1'b1; wt(10);

    // R2 R5 R6 basic write, R8 read back
    strap = 3'b101;
    write_reg(addr_byte(3'b101, 0), 8'h03, 16'hBEEF, 0, acks);
    chk(acks == 3'b111, "R2 R5 R6 write acks", acks, 3'b111);
    chk(mem[3] == 16'hBEEF, "R6 write data", mem[3], 16'hBEEF);
    chk(reg_addr == 4'd3, "R5 pointer on port", reg_addr, 3);
    read_n(addr_byte(3'b101, 1), 2, k, v);
    chk(k && v[15:0] == 16'hBEEF, "R8 read two bytes", v[15:0], 16'hBEEF);

    // R3 general call and wrong address
    w0 = wr_cnt;
    write_reg(8'h00, 8'h05, 16'h1234, 0, acks);
    chk(acks == 3'b000, "R3 general call ignored", acks, 0);
    write_reg(addr_byte(3'b100, 0), 8'h05, 16'h1234, 0, acks);
    chk(acks == 3'b000 && wr_cnt == w0 && reg_addr == 4'd3, "R3 wrong address ignored",
        {acks, reg_addr}, {3'b000, 4'd3});

    // R4 straps change after START
    bus_start; strap = 3'b010;
    wbyte(addr_byte(3'b101, 0), 0, k);
    bus_stop;
    chk(k, "R4 straps held from START", k, 1);
    bus_start;
    wbyte(addr_byte(3'b010, 0), 0, k);
    bus_stop;
    chk(k, "R4 new straps at next START", k, 1);

    // R7 pointer-only write then repeated START read (R9)
    w0 = wr_cnt;
    bus_start;
    wbyte(addr_byte(3'b010, 0), 0, k);
    wbyte(8'h07, 0, k);
    bus_start;
    wbyte(addr_byte(3'b010, 1), 0, k);
    rbyte(1'b1, v[15:8]); rbyte(1'b1, v[7:0]); rbyte(1'b0, v[23:16]);
    bus_stop;
    chk(wr_cnt == w0, "R7 pointer-only no write", wr_cnt - w0, 0);
    chk(v[15:0] == 16'h1007, "R9 repeated START read", v[15:0], 16'h1007);
    chk(v[23:16] == 8'h10, "R8 third byte wraps to high", v[23:16], 8'h10);

    // R7 stop after one data byte
    bus_start;
    wbyte(addr_byte(3'b010, 0), 0, k);
    wbyte(8'h09, 0, k);
    wbyte(8'hAA, 0, k);
    bus_stop;
    chk(wr_cnt == w0 && mem[9] == 16'h1009, "R7 R9 stop after one byte", mem[9], 16'h1009);

    // R6 third data byte NACKed, single write
    bus_start;
    wbyte(addr_byte(3'b010, 0), 0, k);
    wbyte(8'h02, 0, k); wbyte(8'h55, 0, k); wbyte(8'h66, 0, k);
    wbyte(8'h77, 0, k);
    bus_stop;
    chk(!k && wr_cnt == w0 + 1 && mem[2] == 16'h5566, "R6 extra byte nack",
        {k, mem[2]}, {1'b0, 16'h5566});

    // R10 glitch on SDA while SCL high
    write_reg(addr_byte(3'b010, 0), 8'h0A, 16'hF0F3, 1, acks);
    chk(acks == 3'b111 && mem[10] == 16'hF0F3, "R10 glitch ignored", mem[10], 16'hF0F3);

    // R11 timeout during address ACK
    bus_start;
    send8(addr_byte(3'b010, 0), 0);
    wt(TO - 30);
    chk(sda_oe, "R11 ack still driven before window", sda_oe, 1);
    wt(70);
    chk(!sda_oe, "R11 released after timeout", sda_oe, 0);
    m_low = 1'b0; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    bus_stop;
    // disabled timeout holds
    to_en = 1'b0;
    bus_start;
    send8(addr_byte(3'b010, 0), 0);
    wt(TO + 200);
    chk(sda_oe, "R11 disabled holds drive", sda_oe, 1);
    m_low = 1'b0; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(H);
    chk(!sda_oe, "R11 ack ends on clock", sda_oe, 0);
    bus_stop;
    to_en = 1'b1;

    // random write/read-back pairs
    for (int it = 0; it < 12; it++) begin
      logic [2:0] s;
      logic [3:0] p;
      logic [15:0] d;
      s = 3'($urandom); p = 4'($urandom); d = 16'($urandom);
      strap = s;
      write_reg(addr_byte(s, 0), {4'($urandom), p}, d, 0, acks);
      read_n(addr_byte(s, 1), 2, k, v);
      chk(acks == 3'b111 && k && v[15:0] == d && reg_addr == p, "R2 R6 R8 random pair",
          v[15:0], d);
    end
    chk(!sda_oe, "R8 R9 released when idle", sda_oe, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule